// File: doc/BRIEF.md
# Peripheral Bus Address Map Unit

This block relocates DMA addresses that arrive from an 18-bit legacy peripheral bus into a 22-bit physical memory space. The 18-bit address space is cut into 32 pages of 8 KB each. Address bits 17:13 pick one of 32 relocation entries. The 22-bit base held in that entry is added to the 13-bit offset within the page, and the sum is the physical address.

Software programs the entries through a small register port. Each entry takes two consecutive 16-bit words, and only some bits of each word are implemented. A single enable bit sits in a separate memory-management control register. Relocation applies only when that enable bit is set and the access carries the peripheral-bus qualifier. Every other access, and any qualified access that falls in the top page (the I/O page), passes through unchanged and zero-extended. A top-page access also raises a flag so that the surrounding fabric can route it to I/O.

The translation path is purely combinational. Register reads are combinational. Register writes land on the next rising clock edge.

Top module: `bus_map_unit`

## Requirements
- R1: The map occupies 64 consecutive 16-bit words starting at byte address octal 170200. Entry k has its low word at 170200+4k and its high word at 170202+4k. A register address outside the map and the control register reads as zero, and a write there changes nothing.
- R2: In a low word, bits 15:1 are stored and bit 0 always reads 0. Writing 177777 reads back as 177776.
- R3: In a high word, bits 5:0 are stored and bits 15:6 always read 0. Writing 177777 reads back as 000077.
- R4: The control register at byte address octal 172516 holds the relocation enable in bit 5 (mask 000040). All its other bits read as zero.
- R5: With enable set, a qualified access whose bits 17:13 are not 31 goes to base + bits 12:0, modulo 2^22. The base is {high[5:0], low[15:1], 0}. Example: entry 1 = 004000 maps 020000 to 004000 and 020200 to 004200.
- R6: An access without the qualifier passes its address through zero-extended, and its I/O-page flag is 0.
- R7: With enable clear, a qualified access passes through unchanged. Example: 020000 goes to 020000.
- R8: A qualified access with bits 17:13 = 31 raises the I/O-page flag and passes through unchanged. Every other access leaves the flag at 0.
- R9: Reset clears the enable bit and every map entry.
- R10: A register write takes effect at the next rising edge. Before that edge, translation still uses the old entry. From that edge on, translation uses the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 15 | Register byte address bits 15:1 |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Register read data, combinational |
| xl_addr | input | 18 | Peripheral-bus address to translate |
| xl_qual | input | 1 | Access originates on the peripheral bus |
| xl_paddr | output | 22 | Physical address |
| xl_iopage | output | 1 | Qualified access falls in the top (I/O) page |

## Verification
On every cycle, the assertions check the following:
- the masked write-then-read of low words, high words and the control register;
- pass-through of unqualified and I/O-page accesses;
- preservation of offset bit 0.

Only the bench scenarios can show the rest:
- the actual relocation arithmetic, including wrap at 2^22;
- the disabled pass-through;
- the clearing by reset;
- the exact edge at which a new entry reaches the translation port.

These need values that are set up over several cycles.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int BUS_AW      = 18;
    localparam int PHYS_AW     = 22;
    localparam int PAGE_BITS   = 13;
    localparam int MAP_ENTRIES = 32;
    localparam int REG_DW      = 16;
    localparam int ENABLE_BIT  = 5;
    localparam logic [15:0] MAP_BASE_ADDR = 16'o170200;
    localparam logic [15:0] CTL_REG_ADDR  = 16'o172516;
endpackage

// File: rtl/bmu_map_regs.sv
module bmu_map_regs
    import bmu_pkg::*;
#(
    parameter int          ENTRIES  = MAP_ENTRIES,
    parameter int          PA_W     = PHYS_AW,
    parameter int          DW       = REG_DW,
    parameter int          EN_BIT   = ENABLE_BIT,
    parameter logic [15:0] MAP_BASE = MAP_BASE_ADDR,
    parameter logic [15:0] CTL_ADDR = CTL_REG_ADDR,
    localparam int         IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:1]      reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             reg_we,
    output logic [DW-1:0]    reg_rdata,
    output logic             map_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base
);
    localparam int HI_W = PA_W - DW;
    localparam int LO_W = DW - 1;

    logic [LO_W-1:0] lo_q [ENTRIES];
    logic [HI_W-1:0] hi_q [ENTRIES];
    logic            en_q;

    logic [14:0]      woff;
    logic             map_hit;
    logic             ctl_hit;
    logic             half_hi;
    logic [IDX_W-1:0] widx;

    assign woff    = reg_addr - MAP_BASE[15:1];
    assign map_hit = woff < 15'(2 * ENTRIES);
    assign ctl_hit = reg_addr == CTL_ADDR[15:1];
    assign half_hi = woff[0];
    assign widx    = woff[IDX_W:1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
            en_q <= 1'b0;
        end else if (reg_we) begin
            if (map_hit && !half_hi) lo_q[widx] <= reg_wdata[DW-1:1];
            if (map_hit && half_hi)  hi_q[widx] <= reg_wdata[HI_W-1:0];
            if (ctl_hit)             en_q       <= reg_wdata[EN_BIT];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (map_hit && !half_hi) begin
            reg_rdata = {lo_q[widx], 1'b0};
        end else if (map_hit) begin
            reg_rdata = {{(DW-HI_W){1'b0}}, hi_q[widx]};
        end else if (ctl_hit) begin
            reg_rdata[EN_BIT] = en_q;
        end
    end

    assign map_en  = en_q;
    assign rd_base = {hi_q[rd_idx], lo_q[rd_idx], 1'b0};
endmodule

// File: rtl/bmu_xlate.sv
module bmu_xlate
    import bmu_pkg::*;
#(
    parameter int  BA_W    = BUS_AW,
    parameter int  PA_W    = PHYS_AW,
    parameter int  PG_BITS = PAGE_BITS,
    parameter int  ENTRIES = MAP_ENTRIES,
    localparam int IDX_W   = BA_W - PG_BITS
) (
    input  logic [BA_W-1:0]  bus_addr,
    input  logic             qual,
    input  logic             map_en,
    input  logic [PA_W-1:0]  base,
    output logic [IDX_W-1:0] page_idx,
    output logic [PA_W-1:0]  phys_addr,
    output logic             io_page
);
    localparam logic [IDX_W-1:0] IO_IDX = IDX_W'(ENTRIES - 1);

    logic [PA_W-1:0] offset_ext;
    logic [PA_W-1:0] reloc_sum;
    logic            relocate;

    assign page_idx   = bus_addr[BA_W-1:PG_BITS];
    assign io_page    = qual && (page_idx == IO_IDX);
    assign relocate   = qual && map_en && !io_page;
    assign offset_ext = {{(PA_W-PG_BITS){1'b0}}, bus_addr[PG_BITS-1:0]};
    assign reloc_sum  = base + offset_ext;

    always_comb begin
        if (relocate) phys_addr = reloc_sum;
        else          phys_addr = {{(PA_W-BA_W){1'b0}}, bus_addr};
    end
endmodule

// File: rtl/bus_map_unit.sv
module bus_map_unit
    import bmu_pkg::*;
#(
    parameter int BA_W    = BUS_AW,
    parameter int PA_W    = PHYS_AW,
    parameter int PG_BITS = PAGE_BITS,
    parameter int ENTRIES = MAP_ENTRIES,
    parameter int DW      = REG_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:1]     reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            reg_we,
    output logic [DW-1:0]   reg_rdata,
    input  logic [BA_W-1:0] xl_addr,
    input  logic            xl_qual,
    output logic [PA_W-1:0] xl_paddr,
    output logic            xl_iopage
);
    localparam int IDX_W = BA_W - PG_BITS;

    logic             map_en;
    logic [IDX_W-1:0] page_idx;
    logic [PA_W-1:0]  page_base;

    bmu_map_regs #(
        .ENTRIES (ENTRIES),
        .PA_W    (PA_W),
        .DW      (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .map_en    (map_en),
        .rd_idx    (page_idx),
        .rd_base   (page_base)
    );

    bmu_xlate #(
        .BA_W    (BA_W),
        .PA_W    (PA_W),
        .PG_BITS (PG_BITS),
        .ENTRIES (ENTRIES)
    ) u_xlate (
        .bus_addr  (xl_addr),
        .qual      (xl_qual),
        .map_en    (map_en),
        .base      (page_base),
        .page_idx  (page_idx),
        .phys_addr (xl_paddr),
        .io_page   (xl_iopage)
    );
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
    import bmu_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:1]           reg_addr,
    input logic [REG_DW-1:0]     reg_wdata,
    input logic                  reg_we,
    input logic [REG_DW-1:0]     reg_rdata,
    input logic [BUS_AW-1:0]     xl_addr,
    input logic                  xl_qual,
    input logic [PHYS_AW-1:0]    xl_paddr,
    input logic                  xl_iopage
);
    logic [14:0] chk_off;
    logic        chk_lo, chk_hi, chk_ctl, chk_io;
    logic [PHYS_AW-1:0] chk_pass;

    assign chk_off  = reg_addr - MAP_BASE_ADDR[15:1];
    assign chk_lo   = (chk_off < 15'(2 * MAP_ENTRIES)) && !chk_off[0];
    assign chk_hi   = (chk_off < 15'(2 * MAP_ENTRIES)) && chk_off[0];
    assign chk_ctl  = reg_addr == CTL_REG_ADDR[15:1];
    assign chk_io   = xl_addr[BUS_AW-1:PAGE_BITS] == (BUS_AW-PAGE_BITS)'(MAP_ENTRIES - 1);
    assign chk_pass = {{(PHYS_AW-BUS_AW){1'b0}}, xl_addr};

    AST_LOW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_we) && $past(chk_lo) && reg_addr == $past(reg_addr))
        |-> reg_rdata == ($past(reg_wdata) & 16'hFFFE)); // R2

    AST_HIGH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_we) && $past(chk_hi) && reg_addr == $past(reg_addr))
        |-> reg_rdata == ($past(reg_wdata) & 16'h003F)); // R3

    AST_CTL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_we) && $past(chk_ctl) && reg_addr == $past(reg_addr))
        |-> reg_rdata == ($past(reg_wdata) & 16'h0020)); // R4

    AST_UNQUAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_qual |-> (xl_paddr == chk_pass && !xl_iopage)); // R6

    AST_IOPAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_qual && chk_io) |-> (xl_iopage && xl_paddr == chk_pass)); // R8

    AST_OFFSET_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        xl_paddr[0] == xl_addr[0]); // R5
endmodule

bind bus_map_unit bmu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .xl_addr   (xl_addr),
    .xl_qual   (xl_qual),
    .xl_paddr  (xl_paddr),
    .xl_iopage (xl_iopage)
);

// File: tb/sim_bus_map_unit.sv
module sim_bus_map_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {byte address, write data, expected readback, requirement number}
    localparam logic [51:0] VEC_TAB [NVEC] = '{
        {16'o170200, 16'o177777, 16'o177776, 4'd2},  // R2 low word entry 0
        {16'o170202, 16'o177777, 16'o000077, 4'd3},  // R3 high word entry 0
        {16'o170224, 16'o125252, 16'o125252, 4'd2},  // R2 entry 5 low
        {16'o170226, 16'o125252, 16'o000052, 4'd3},  // R3 entry 5 high
        {16'o170374, 16'o000001, 16'o000000, 4'd2},  // R2 entry 31 low
        {16'o170376, 16'o177700, 16'o000000, 4'd3},  // R3 entry 31 high
        {16'o172516, 16'o177777, 16'o000040, 4'd4},  // R4 enable set
        {16'o172516, 16'o000000, 16'o000000, 4'd4},  // R4 enable clear
        {16'o170400, 16'o177777, 16'o000000, 4'd1},  // R1 above map
        {16'o170176, 16'o177777, 16'o000000, 4'd1}   // R1 below map
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic [17:0] xl_addr = '0;
    logic        xl_qual = 1'b0;
    logic [21:0] xl_paddr;
    logic        xl_iopage;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_map_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .xl_addr(xl_addr),
        .xl_qual(xl_qual), .xl_paddr(xl_paddr), .xl_iopage(xl_iopage)
    );

    task automatic wr(input logic [15:0] ba, input logic [15:0] d);
        @(negedge clk);
        reg_addr = ba[15:1]; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] ba, input logic [15:0] exp, input string req);
        @(negedge clk);
        reg_addr = ba[15:1];
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read %o: got %o expected %o", req, ba, reg_rdata, exp);
        end
    endtask

    task automatic xl(input logic [17:0] a, input logic q, input logic [21:0] exp_pa,
                      input logic exp_io, input string req);
        @(negedge clk);
        xl_addr = a; xl_qual = q;
        #1;
        n_cmp++;
        if (xl_paddr !== exp_pa || xl_iopage !== exp_io) begin
            n_bad++;
            $display("FAIL %s xlate %o: got %o/%b expected %o/%b",
                     req, a, xl_paddr, xl_iopage, exp_pa, exp_io);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        rd(16'o170200, 16'o0, "R9");
        rd(16'o170376, 16'o0, "R9");
        rd(16'o172516, 16'o0, "R9");

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC_TAB[v][51:36], VEC_TAB[v][35:20]);
            rd(VEC_TAB[v][51:36], VEC_TAB[v][19:4], $sformatf("R%0d", VEC_TAB[v][3:0]));
        end

        // R1: every word of the map, distinct data
        for (int k = 0; k < 64; k++)
            wr(16'o170200 + 16'(2*k), 16'(k * 16'h0421) ^ 16'h5A5A);
        for (int k = 0; k < 64; k++) begin
            logic [15:0] d;
            d = 16'(k * 16'h0421) ^ 16'h5A5A;
            rd(16'o170200 + 16'(2*k), (k % 2 == 0) ? (d & 16'hFFFE) : (d & 16'h003F), "R1");
        end

        // R7: relocation disabled
        wr(16'o170200, 16'o0); wr(16'o170202, 16'o0);
        wr(16'o170204, 16'o004000); wr(16'o170206, 16'o0);
        wr(16'o172516, 16'o0);
        xl(18'o020000, 1'b1, 22'o020000, 1'b0, "R7");

        // R5: relocation enabled
        wr(16'o172516, 16'o000040);
        xl(18'o020000, 1'b1, 22'o004000, 1'b0, "R5");
        xl(18'o020200, 1'b1, 22'o004200, 1'b0, "R5");
        xl(18'o000010, 1'b1, 22'o000010, 1'b0, "R5");
        // R6: no qualifier
        xl(18'o020200, 1'b0, 22'o020200, 1'b0, "R6");
        xl(18'o760100, 1'b0, 22'o760100, 1'b0, "R6");
        // R8: top page
        xl(18'o760100, 1'b1, 22'o760100, 1'b1, "R8");
        // R5: wrap at 2^22 with full base in entry 2
        wr(16'o170210, 16'o177776); wr(16'o170212, 16'o000077);
        xl(18'h05FFF, 1'b1, 22'h001FFD, 1'b0, "R5");

        // R10: write timing against translation
        wr(16'o170214, 16'o0); wr(16'o170216, 16'o0);
        xl(18'o060000, 1'b1, 22'o0, 1'b0, "R10");
        @(negedge clk);
        reg_addr = 15'(16'o170214 >> 1); reg_wdata = 16'o010000; reg_we = 1'b1;
        #1;
        n_cmp++;
        if (xl_paddr !== 22'o0) begin
            n_bad++; $display("FAIL R10 before edge: got %o expected %o", xl_paddr, 22'o0);
        end
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        n_cmp++;
        if (xl_paddr !== 22'o010000) begin
            n_bad++; $display("FAIL R10 after edge: got %o expected %o", xl_paddr, 22'o010000);
        end

        // R9: reset clears enable and entries
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(16'o172516, 16'o0, "R9");
        rd(16'o170204, 16'o0, "R9");
        xl(18'o020000, 1'b1, 22'o020000, 1'b0, "R9");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule